// File: doc/BRIEF.md
# Transmit Holding Buffer with DMA Pacing

This block is the transmit holding path of an asynchronous serial port. A host writes bytes through a byte-wide write port. The bytes queue in a first-in first-out buffer and leave in order through a valid/ready pop port that feeds a serializer. An active-low ready output paces an external DMA controller.

Two control inputs set the behaviour. The first selects buffered mode, with a deep buffer, or legacy mode, where a single byte is held. The second picks the pacing style used in buffered mode. The single-transfer style asks for one byte whenever the buffer is empty. The burst style keeps asking until the buffer is full and starts again only once the buffer has drained. Legacy mode always uses single-transfer pacing. A write that finds no room is dropped and raises a sticky overflow flag, which stays set until it is cleared.

Top module: `tx_hold_dma`

## Requirements
- R1: A byte is stored only on a clock edge where `sel` and `wr_en` are both high. Stored bytes leave the pop port in the order they were written.
- R2: With `fifo_on`=1 the buffer holds DEPTH (default 64) bytes. With `fifo_on`=0 it holds one byte.
- R3: A write when the buffer is full is dropped and sets `ovf_flag`. The flag stays high until a cycle with `ovf_clr`=1, and a new overflow in that same cycle wins over the clear.
- R4: `pop_valid` is high exactly when the buffer holds at least one byte, and `pop_data` then shows the oldest byte. A pop (`pop_valid` and `pop_ready` high) removes that byte. A pop and an accepted write in the same cycle leave the fill level unchanged.
- R5: In single-transfer pacing (`fifo_on`=1, `burst_sel`=0), `dma_rdy_n` one clock after an edge is 0 if the buffer was empty at that edge and 1 otherwise.
- R6: In burst pacing (`fifo_on`=1, `burst_sel`=1), `dma_rdy_n` goes to 0 one clock after the buffer is seen empty and goes to 1 one clock after it is seen full. Between those two events it keeps its value.
- R7: With `fifo_on`=0, pacing follows the R5 rule whatever the value of `burst_sel`.
- R8: A change of `fifo_on` empties the buffer by the next edge. Writes, pops and overflow detection in that cycle are ignored.
- R9: While `rst` is high at a clock edge, the buffer is emptied and the block powers up in legacy mode. After the edge, `pop_valid`=0, `dma_rdy_n`=0 and `ovf_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Chip select, active high |
| wr_en | input | 1 | Write strobe, active high |
| wr_data | input | 8 | Byte to store |
| fifo_on | input | 1 | 1 = buffered mode, 0 = single holding byte |
| burst_sel | input | 1 | 1 = burst pacing (only honoured with fifo_on=1) |
| ovf_clr | input | 1 | Clears the overflow flag |
| pop_ready | input | 1 | Serializer takes the byte this cycle |
| pop_valid | output | 1 | A byte is waiting |
| pop_data | output | 8 | Oldest stored byte |
| dma_rdy_n | output | 1 | DMA request pacing, active low |
| ovf_flag | output | 1 | Sticky overflow indicator |

## Verification
Random traffic is run in legacy mode with `burst_sel` toggling. This shows whether burst pacing leaks into legacy mode and whether the capacity really stays at one byte. In buffered mode the traffic is biased toward writes in some stretches and toward pops in others. The write-heavy stretches reach the full level, which separates burst pacing from single-transfer pacing. The pop-heavy stretches walk the ready output through its hold region. Directed sequences cover a clean fill to DEPTH, one write past full, the drain back to empty, a mode change that flushes while a write is pending, and a write with chip select low.

// File: rtl/tx_hold_pkg.sv
`timescale 1ns/1ps
package tx_hold_pkg;
  typedef enum logic {PACE_SINGLE = 1'b0, PACE_BURST = 1'b1} pace_e;
endpackage

// File: rtl/tx_hold_store.sv
`timescale 1ns/1ps
module tx_hold_store #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         deep,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop_rdy,
  output logic                         pop_vld,
  output logic [W-1:0]                 rdata,
  output logic                         empty,
  output logic                         full,
  output logic                         push_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_nx, rp_nx;
  logic [CW-1:0] level, cap;
  logic          push_ok, pop_ok;

  assign cap       = deep ? CW'(DEPTH) : CW'(1);
  assign empty     = (level == '0);
  assign full      = (level == cap);
  assign pop_vld   = ~empty;
  assign push_ok   = push & ~full & ~flush;
  assign pop_ok    = pop_vld & pop_rdy & ~flush;
  assign push_drop = push & full & ~flush;
  assign rdata     = mem[rp];

  generate
    if (POW2) begin : g_wrap_nat
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
    end else begin : g_wrap_cmp
      assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= wp_nx;
      if (pop_ok)  rp <= rp_nx;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R2: fill level never exceeds the capacity of the current mode
  p_cap_r2: assert property (@(posedge clk) disable iff (rst)
    !flush |=> level <= cap);
  // R4: simultaneous accepted write and pop keep the level
  p_keep_level_r4: assert property (@(posedge clk) disable iff (rst)
    (push && !full && pop_vld && pop_rdy && !flush) |=> $stable(level));
  // R8: a flush leaves the buffer empty
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/tx_hold_pacer.sv
`timescale 1ns/1ps
module tx_hold_pacer
  import tx_hold_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  pace_e mode,
  input  logic  empty,
  input  logic  full,
  output logic  rdy_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_n <= 1'b0;
    end else if (mode == PACE_SINGLE) begin
      rdy_n <= ~empty;
    end else if (empty) begin
      rdy_n <= 1'b0;
    end else if (full) begin
      rdy_n <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_hold_dma.sv
`timescale 1ns/1ps
module tx_hold_dma
  import tx_hold_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         fifo_on,
  input  logic         burst_sel,
  input  logic         ovf_clr,
  input  logic         pop_ready,
  output logic         pop_valid,
  output logic [W-1:0] pop_data,
  output logic         dma_rdy_n,
  output logic         ovf_flag
);
  logic  fifo_on_q, flush, push, empty, full, push_drop;
  pace_e mode;

  assign flush = fifo_on ^ fifo_on_q;
  assign push  = sel & wr_en;
  assign mode  = (fifo_on_q & burst_sel) ? PACE_BURST : PACE_SINGLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_on_q <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      fifo_on_q <= fifo_on;
      if (push_drop)    ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end

  tx_hold_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .deep(fifo_on_q),
    .push(push), .wdata(wr_data), .pop_rdy(pop_ready),
    .pop_vld(pop_valid), .rdata(pop_data),
    .empty(empty), .full(full), .push_drop(push_drop)
  );

  tx_hold_pacer u_pacer (
    .clk(clk), .rst(rst), .mode(mode),
    .empty(empty), .full(full), .rdy_n(dma_rdy_n)
  );

  // R3: a write into a full buffer raises the flag
  p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
    (sel && wr_en && full && !flush) |=> ovf_flag);
  // R3: the flag holds until cleared
  p_ovf_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R5: single pacing drops the request once a byte is stored
  p_single_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == PACE_SINGLE && !empty) |=> dma_rdy_n);
  // R6: burst pacing withdraws the request at full
  p_burst_full_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == PACE_BURST && full) |=> dma_rdy_n);
  // R5 / R6: an empty buffer always asks for data
  p_empty_asks_r6: assert property (@(posedge clk) disable iff (rst)
    empty |=> !dma_rdy_n);
endmodule

// File: tb/sim_tx_hold_dma.sv
`timescale 1ns/1ps
module sim_tx_hold_dma;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, wr_en = 1'b0, fifo_on = 1'b0, burst_sel = 1'b0;
  logic ovf_clr = 1'b0, pop_ready = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic pop_valid, dma_rdy_n, ovf_flag;
  logic [7:0] pop_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [7:0] mq[$];
  logic m_rdy_n = 1'b0, m_ovf = 1'b0, m_fon_q = 1'b0;
  string pace_tag = "R9";

  always #10 clk = ~clk;

  tx_hold_dma #(.DEPTH(DEPTH), .W(8)) u0 (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_on(fifo_on), .burst_sel(burst_sel), .ovf_clr(ovf_clr),
    .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_data(pop_data),
    .dma_rdy_n(dma_rdy_n), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cap_of(input logic deep);
    return deep ? DEPTH : 1;
  endfunction

  task automatic model_edge();
    int  cnt = mq.size();
    bit  flush, full, push;
    if (rst) begin
      mq.delete(); m_rdy_n = 1'b0; m_ovf = 1'b0; m_fon_q = 1'b0; pace_tag = "R9";
      return;
    end
    flush = (fifo_on != m_fon_q);
    full  = (cnt == cap_of(m_fon_q));
    push  = sel && wr_en;
    if (!m_fon_q) begin
      pace_tag = "R7"; m_rdy_n = (cnt != 0);
    end else if (!burst_sel) begin
      pace_tag = "R5"; m_rdy_n = (cnt != 0);
    end else begin
      pace_tag = "R6";
      if (cnt == 0) m_rdy_n = 1'b0;
      else if (full) m_rdy_n = 1'b1;
    end
    if (push && full && !flush) m_ovf = 1'b1;
    else if (ovf_clr) m_ovf = 1'b0;
    if (flush) mq.delete();
    else begin
      if (cnt != 0 && pop_ready) void'(mq.pop_front());
      if (push && !full) mq.push_back(wr_data);
    end
    m_fon_q = fifo_on;
  endtask

  task automatic compare();
    chk("R4 pop_valid", pop_valid, mq.size() != 0);
    if (mq.size() != 0) chk("R1 pop_data order", pop_data, mq[0]);
    chk({pace_tag, " dma_rdy_n"}, dma_rdy_n, m_rdy_n);
    chk("R3 ovf_flag", ovf_flag, m_ovf);
  endtask

  task automatic step(input logic c, input logic we, input logic [7:0] d,
                      input logic fo, input logic bs, input logic clr, input logic pr);
    sel = c; wr_en = we; wr_data = d; fifo_on = fo; burst_sel = bs;
    ovf_clr = clr; pop_ready = pr;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic rnd_steps(input int n, input logic fo, input int bs_mode,
                           input int p_push, input int p_pop);
    for (int i = 0; i < n; i++) begin
      logic bs = (bs_mode == 2) ? 1'($urandom % 2) : 1'(bs_mode);
      step(($urandom % 8) != 0, ($urandom % 100) < p_push, 8'($urandom),
           fo, bs, ($urandom % 20) == 0, ($urandom % 100) < p_pop);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    step(0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 8'h11, 0, 1, 0, 0);
    // R9: reset state
    chk("R9 pop_valid", pop_valid, 0);
    chk("R9 dma_rdy_n", dma_rdy_n, 0);
    chk("R9 ovf_flag", ovf_flag, 0);
    rst = 1'b0;

    // R1: chip select low blocks the write
    step(0, 1, 8'hA5, 0, 0, 0, 0);
    chk("R1 write without select", pop_valid, 0);

    // R7 / R2: legacy mode, single byte, burst_sel toggling
    rnd_steps(300, 0, 2, 60, 50);

    // enter buffered mode (flush edge), burst pacing
    step(0, 0, 0, 1, 1, 1, 0);
    while (mq.size() != 0) step(0, 0, 0, 1, 1, 1, 1);
    for (int i = 0; i < DEPTH; i++) step(1, 1, 8'(i * 7 + 3), 1, 1, 0, 0);
    chk("R2 full at DEPTH, valid", pop_valid, 1);
    chk("R2 no overflow at DEPTH", ovf_flag, 0);
    step(1, 1, 8'hEE, 1, 1, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0);
    chk("R3 overflow past DEPTH", ovf_flag, 1);
    chk("R6 burst idle when full", dma_rdy_n, 1);
    step(0, 0, 0, 1, 1, 1, 0);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 1, 0, 1);
    chk("R2 empty after DEPTH pops", pop_valid, 0);
    step(0, 0, 0, 1, 1, 0, 0);
    chk("R6 burst asks when empty", dma_rdy_n, 0);

    // R5: single-transfer pacing
    rnd_steps(400, 1, 0, 70, 40);
    rnd_steps(400, 1, 0, 30, 80);
    // R6: burst pacing, fill-heavy and drain-heavy
    for (int k = 0; k < 4; k++) begin
      rnd_steps(200, 1, 1, 85, 20);
      rnd_steps(200, 1, 1, 20, 85);
    end

    // R8: flush with a write pending
    for (int i = 0; i < 5; i++) step(1, 1, 8'(i), 1, 0, 0, 0);
    step(1, 1, 8'h77, 0, 0, 0, 1);
    chk("R8 flush empties", pop_valid, 0);
    chk("R8 flush blocks overflow", ovf_flag, m_ovf);

    // mixed traffic with occasional mode changes
    for (int k = 0; k < 10; k++) begin
      rnd_steps(150, 1'($urandom % 2), 2, 55, 50);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule